// File: doc/BRIEF.md
# Queued Serial Peripheral Master

This block is a serial peripheral master that works through a list of transfers on its own. It holds sixteen queue entries. Each entry has a command byte, a transmit word and a receive word. A host loads the entries through a small register-style port. It then sets a first-entry and a last-entry index, the clock polarity, the clock phase and a clock divider, and starts the run with one write.

The engine then visits the entries in order from the first index to the last. It wraps from entry 15 to entry 0 when the last index is below the first. For each entry it drives that entry's 4-bit chip-select code and shifts that entry's number of bits, most significant bit first, while it collects the bits that arrive on the data input. At the end of each entry the collected bits go back into that entry's receive word. Between entries the chip-select lines return to all ones. A done flag marks the end of the run and stays set until the next start.

Host address map (hostAddr is 6 bits). Bits [5:4] pick the region: 0 is the command array, 1 the transmit array, 2 the receive array (read only), and 3 the control registers. Bits [3:0] give the entry index, or, in region 3, bits [1:0] give the control register:
- 0: pointers, with the first index in [3:0] and the last index in [7:4].
- 1: mode, with polarity in bit 0 and phase in bit 1.
- 2: divider value, 8 bits.
- 3: a write starts the run; a read returns done in bit 0 and busy in bit 1.

Top module: `queued_spi_master`

## Requirements
- R1: After reset, chipSel is 4'hF, sclk is 0, sdo is 0 and done is 0.
- R2: The host port writes the command array (low 8 bits), the transmit array (16 bits), the pointer register (low 8 bits), the mode register (2 bits) and the divider (8 bits). It reads all of them back, together with the receive array, with the map above.
- R3: A run visits the entries from the first index to the last, in rising order, wrapping from 15 to 0. When the two indices are equal, exactly one entry is sent.
- R4: During an entry, chipSel equals command bits [3:0] of that entry. Outside an entry, chipSel is 4'hF.
- R5: An entry moves (command bits [7:4]) + 1 bits, from 1 to 16. It sends the low bits of the transmit word that many, most significant first.
- R6: After an entry, its receive word holds the bits taken in, with the last one in bit 0 and zeros above the bit length.
- R7: sclk rests at the polarity bit when no entry is active. With phase 0, data is taken on the first clock edge of each bit and changed on the second. With phase 1, data is changed on the first edge and taken on the second.
- R8: Each sclk half period, and the time from chip-select assertion to the first edge, lasts divider + 1 system clocks.
- R9: done is set once the last entry finishes. It stays set until the next start write, which clears it.
- R10: While a run is active, all host writes are ignored, including start writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| hostWe | input | 1 | Host write strobe |
| hostAddr | input | 6 | Host register address |
| hostWdata | input | 16 | Host write data |
| hostRdata | output | 16 | Host read data (combinational) |
| sclk | output | 1 | Serial clock |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |
| chipSel | output | 4 | Chip-select code, all ones when inactive |
| done | output | 1 | Run finished |

## Verification
The hardest case to reach from the ports is a write that lands while a run is in flight. The bench therefore starts a four-entry run that wraps around entry 15. It picks a slow divider and 16-bit entries, so the run lasts long enough for several writes to land in its middle: new pointers, a fresh start, and a new transmit word for an entry that has not yet been loaded. The frames that follow, and a later read of the pointer register, must show that none of these writes took effect. Each of the four polarity and phase pairs is driven by a bench slave that samples and drives on the edges the mode defines.

// File: rtl/qspim_pkg.sv
package qspim_pkg;
  typedef struct packed {
    logic loadEntry;
    logic shiftOut;
    logic sampleIn;
    logic storeRx;
  } qspimStrobe_t;

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_CLOCK, ST_GAP} qspimState_t;
endpackage

// File: rtl/qspim_ctrl.sv
module qspim_ctrl
  import qspim_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int CS_W   = 4,
  parameter int LEN_W  = 4,
  parameter int DIV_W  = 8,
  localparam int CMD_W = CS_W + LEN_W,
  localparam int EDGE_W = LEN_W + 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             goPulse,
  input  logic [IDX_W-1:0] startPtr,
  input  logic [IDX_W-1:0] endPtr,
  input  logic             cpol,
  input  logic             cpha,
  input  logic [DIV_W-1:0] divVal,
  input  logic [CMD_W-1:0] curCmd,
  output logic [IDX_W-1:0] ptr,
  output qspimStrobe_t     strobe,
  output logic             sclk,
  output logic [CS_W-1:0]  chipSel,
  output logic             done,
  output logic             busy
);
  qspimState_t state;
  logic [DIV_W-1:0]  halfCnt;
  logic [EDGE_W-1:0] edgeCnt;
  logic [LEN_W:0]    bitLen;
  logic [EDGE_W-1:0] totalEdges;
  logic              tick;
  logic              lead;

  assign bitLen     = {1'b0, curCmd[CMD_W-1:CS_W]} + 1'b1;
  assign totalEdges = {bitLen, 1'b0};
  assign tick       = (halfCnt == divVal);
  assign lead       = ~edgeCnt[0];
  assign busy       = (state != ST_IDLE);

  always_comb begin
    strobe = '0;
    strobe.loadEntry = (state == ST_LOAD);
    if (state == ST_CLOCK && tick) begin
      if (edgeCnt == totalEdges) begin
        strobe.storeRx = 1'b1;
      end else begin
        strobe.sampleIn = cpha ? ~lead : lead;
        strobe.shiftOut = cpha ? lead : ~lead;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      ptr     <= '0;
      halfCnt <= '0;
      edgeCnt <= '0;
      sclk    <= 1'b0;
      chipSel <= '1;
      done    <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          sclk    <= cpol;
          chipSel <= '1;
          halfCnt <= '0;
          if (goPulse) begin
            ptr   <= startPtr;
            done  <= 1'b0;
            state <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          chipSel <= curCmd[CS_W-1:0];
          edgeCnt <= '0;
          halfCnt <= '0;
          sclk    <= cpol;
          state   <= ST_CLOCK;
        end
        ST_CLOCK: begin
          if (tick) begin
            halfCnt <= '0;
            if (edgeCnt == totalEdges) begin
              chipSel <= '1;
              state   <= ST_GAP;
            end else begin
              sclk    <= ~sclk;
              edgeCnt <= edgeCnt + 1'b1;
            end
          end else begin
            halfCnt <= halfCnt + 1'b1;
          end
        end
        default: begin
          if (tick) begin
            halfCnt <= '0;
            if (ptr == endPtr) begin
              done  <= 1'b1;
              state <= ST_IDLE;
            end else begin
              ptr   <= ptr + 1'b1;
              state <= ST_LOAD;
            end
          end else begin
            halfCnt <= halfCnt + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/qspim_dpath.sv
module qspim_dpath
  import qspim_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int DATA_W  = 16,
  parameter int CS_W    = 4,
  parameter int DIV_W   = 8,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int LEN_W  = $clog2(DATA_W),
  localparam int CMD_W  = CS_W + LEN_W,
  localparam int ADDR_W = IDX_W + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWe,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata,
  input  logic              busy,
  input  logic              done,
  input  logic [IDX_W-1:0]  ptr,
  input  qspimStrobe_t      strobe,
  input  logic              sdi,
  output logic              sdo,
  output logic              goPulse,
  output logic [IDX_W-1:0]  startPtr,
  output logic [IDX_W-1:0]  endPtr,
  output logic              cpol,
  output logic              cpha,
  output logic [DIV_W-1:0]  divVal,
  output logic [CMD_W-1:0]  curCmd
);
  logic [CMD_W-1:0]  cmdMem [ENTRIES];
  logic [DATA_W-1:0] txMem  [ENTRIES];
  logic [DATA_W-1:0] rxMem  [ENTRIES];
  logic [DATA_W-1:0] txSh;
  logic [DATA_W-1:0] rxSh;
  logic [DATA_W-1:0] aligned;
  logic [LEN_W:0]    bitLen;
  logic [1:0]        region;
  logic [IDX_W-1:0]  idx;
  logic              wrOk;

  assign region  = hostAddr[ADDR_W-1:IDX_W];
  assign idx     = hostAddr[IDX_W-1:0];
  assign wrOk    = hostWe && !busy;
  assign goPulse = wrOk && (region == 2'd3) && (idx[1:0] == 2'd3);
  assign curCmd  = cmdMem[ptr];
  assign bitLen  = {1'b0, curCmd[CMD_W-1:CS_W]} + 1'b1;
  assign aligned = txMem[ptr] << ((LEN_W+1)'(DATA_W) - bitLen);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) begin
        cmdMem[i] <= '0;
        txMem[i]  <= '0;
      end
      startPtr <= '0;
      endPtr   <= '0;
      cpol     <= 1'b0;
      cpha     <= 1'b0;
      divVal   <= '0;
    end else if (wrOk) begin
      case (region)
        2'd0: cmdMem[idx] <= hostWdata[CMD_W-1:0];
        2'd1: txMem[idx]  <= hostWdata;
        2'd3: begin
          case (idx[1:0])
            2'd0: begin
              startPtr <= hostWdata[IDX_W-1:0];
              endPtr   <= hostWdata[2*IDX_W-1:IDX_W];
            end
            2'd1: begin
              cpol <= hostWdata[0];
              cpha <= hostWdata[1];
            end
            2'd2: divVal <= hostWdata[DIV_W-1:0];
            default: ;
          endcase
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) rxMem[i] <= '0;
      txSh <= '0;
      rxSh <= '0;
      sdo  <= 1'b0;
    end else begin
      if (strobe.loadEntry) begin
        rxSh <= '0;
        if (cpha) begin
          txSh <= aligned;
          sdo  <= 1'b0;
        end else begin
          txSh <= aligned << 1;
          sdo  <= aligned[DATA_W-1];
        end
      end
      if (strobe.shiftOut) begin
        sdo  <= txSh[DATA_W-1];
        txSh <= txSh << 1;
      end
      if (strobe.sampleIn) rxSh <= {rxSh[DATA_W-2:0], sdi};
      if (strobe.storeRx) rxMem[ptr] <= rxSh;
    end
  end

  always_comb begin
    hostRdata = '0;
    case (region)
      2'd0: hostRdata = DATA_W'(cmdMem[idx]);
      2'd1: hostRdata = txMem[idx];
      2'd2: hostRdata = rxMem[idx];
      default: begin
        case (idx[1:0])
          2'd0: hostRdata = DATA_W'({endPtr, startPtr});
          2'd1: hostRdata = DATA_W'({cpha, cpol});
          2'd2: hostRdata = DATA_W'(divVal);
          default: hostRdata = DATA_W'({busy, done});
        endcase
      end
    endcase
  end
endmodule

// File: rtl/queued_spi_master.sv
module queued_spi_master
  import qspim_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int DATA_W  = 16,
  parameter int CS_W    = 4,
  parameter int DIV_W   = 8,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int LEN_W  = $clog2(DATA_W),
  localparam int CMD_W  = CS_W + LEN_W,
  localparam int ADDR_W = IDX_W + 2,
  localparam int CFG_W  = 2 * IDX_W + 2 + DIV_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWe,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata,
  output logic              sclk,
  output logic              sdo,
  input  logic              sdi,
  output logic [CS_W-1:0]   chipSel,
  output logic              done
);
  qspimStrobe_t     strobe;
  logic             busy;
  logic             goPulse;
  logic [IDX_W-1:0] ptr;
  logic [IDX_W-1:0] startPtr;
  logic [IDX_W-1:0] endPtr;
  logic             cpol;
  logic             cpha;
  logic [DIV_W-1:0] divVal;
  logic [CMD_W-1:0] curCmd;
  logic [CFG_W-1:0] cfgWord;

  assign cfgWord = {startPtr, endPtr, cpha, cpol, divVal};

  qspim_ctrl #(.IDX_W(IDX_W), .CS_W(CS_W), .LEN_W(LEN_W), .DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .goPulse(goPulse), .startPtr(startPtr), .endPtr(endPtr),
    .cpol(cpol), .cpha(cpha), .divVal(divVal), .curCmd(curCmd), .ptr(ptr),
    .strobe(strobe), .sclk(sclk), .chipSel(chipSel), .done(done), .busy(busy)
  );

  qspim_dpath #(.ENTRIES(ENTRIES), .DATA_W(DATA_W), .CS_W(CS_W), .DIV_W(DIV_W)) u_dpath (
    .clk(clk), .rstN(rstN), .hostWe(hostWe), .hostAddr(hostAddr), .hostWdata(hostWdata),
    .hostRdata(hostRdata), .busy(busy), .done(done), .ptr(ptr), .strobe(strobe),
    .sdi(sdi), .sdo(sdo), .goPulse(goPulse), .startPtr(startPtr), .endPtr(endPtr),
    .cpol(cpol), .cpha(cpha), .divVal(divVal), .curCmd(curCmd)
  );
endmodule

// File: rtl/qspim_checker.sv
module qspim_checker #(
  parameter int CS_W  = 4,
  parameter int CFG_W = 18
) (
  input logic             clk,
  input logic             rstN,
  input logic             busy,
  input logic             goPulse,
  input logic             cpol,
  input logic             sclk,
  input logic             done,
  input logic [CS_W-1:0]  chipSel,
  input logic [CFG_W-1:0] cfgWord
);
  AST_CS_RELEASED_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> chipSel == '1); // R4
  AST_SCLK_REST_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && $stable(cpol)) |-> sclk == cpol); // R7
  AST_SCLK_QUIET_CS_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (chipSel == '1) |-> $stable(sclk) || !busy); // R4
  AST_DONE_CLEARED_ON_GO: assert property (@(posedge clk) disable iff (!rstN)
    goPulse |=> !done); // R9
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy); // R9
  AST_CFG_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(cfgWord)); // R10
endmodule

bind queued_spi_master qspim_checker #(.CS_W(CS_W), .CFG_W(CFG_W)) u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .goPulse(goPulse), .cpol(cpol),
  .sclk(sclk), .done(done), .chipSel(chipSel), .cfgWord(cfgWord)
);

// File: tb/queued_spi_master_bench.sv
module queued_spi_master_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostWe = 1'b0;
  logic [5:0]  hostAddr = '0;
  logic [15:0] hostWdata = '0;
  logic [15:0] hostRdata;
  logic        sclk, sdo, done;
  logic        sdi = 1'b0;
  logic [3:0]  chipSel;

  int checks = 0;
  int fails = 0;

  typedef struct {
    logic [3:0]  cs;
    int          len;
    logic [15:0] tx;
    logic [15:0] rx;
  } item_t;
  item_t expQ[$];
  logic [15:0] rxExp [16];

  logic cpolT = 1'b0, cphaT = 1'b0;
  int   divT = 0;

  queued_spi_master u_queued_spi_master (
    .clk(clk), .rstN(rstN), .hostWe(hostWe), .hostAddr(hostAddr), .hostWdata(hostWdata),
    .hostRdata(hostRdata), .sclk(sclk), .sdo(sdo), .sdi(sdi), .chipSel(chipSel), .done(done)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] maskOf(input int len);
    return (len >= 16) ? 16'hFFFF : 16'((32'd1 << len) - 1);
  endfunction

  task automatic hostWrite(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    hostWe = 1'b1; hostAddr = a; hostWdata = d;
    @(negedge clk);
    hostWe = 1'b0;
  endtask

  task automatic hostRead(input logic [5:0] a, output logic [15:0] d);
    @(negedge clk);
    hostAddr = a;
    #1 d = hostRdata;
  endtask

  // driver: loads one entry and pushes the frame the slave should see
  task automatic addEntry(input int idx, input logic [3:0] cs, input int len,
                          input logic [15:0] tx, input logic [15:0] rx);
    item_t it;
    hostWrite({2'd0, 4'(idx)}, 16'({4'(len - 1), cs}));
    hostWrite({2'd1, 4'(idx)}, tx);
    it.cs = cs; it.len = len; it.tx = tx; it.rx = rx;
    expQ.push_back(it);
    rxExp[idx] = rx & maskOf(len);
  endtask

  task automatic setMode(input logic pol, input logic pha, input int dv, input int s, input int e);
    hostWrite(6'h31, {14'd0, pha, pol});
    hostWrite(6'h32, 16'(dv));
    hostWrite(6'h30, 16'({4'(e), 4'(s)}));
    cpolT = pol; cphaT = pha; divT = dv;
  endtask

  task automatic waitDone(input string tag);
    int n = 0;
    while (!done && n < 40000) begin
      @(negedge clk);
      n++;
    end
    chk(done === 1'b1, "R9", {tag, " done set"}, int'(done), 1);
    repeat (6) @(negedge clk);
    chk(expQ.size() == 0, "R3", {tag, " all entries sent"}, expQ.size(), 0);
  endtask

  task automatic checkRx(input int idx);
    logic [15:0] v;
    hostRead({2'd2, 4'(idx)}, v);
    chk(v === rxExp[idx], "R6", $sformatf("rx entry %0d", idx), int'(v), int'(rxExp[idx]));
  endtask

  // monitor: bench slave and scoreboard
  logic        inFrame = 1'b0;
  item_t       cur;
  int          bitsSeen = 0;
  int          sinceEdge = 0;
  bit          halfOk = 1'b1;
  bit          csOk = 1'b1;
  logic [15:0] capt = '0;
  logic        sclkPrev = 1'b0;

  always @(negedge clk) begin
    if (rstN) begin
      if (!inFrame && chipSel !== 4'hF) begin
        inFrame = 1'b1;
        if (expQ.size() == 0) begin
          chk(1'b0, "R3", "frame with no entry queued", int'(chipSel), 15);
          cur.cs = chipSel; cur.len = 16; cur.tx = '0; cur.rx = '0;
        end else begin
          cur = expQ.pop_front();
        end
        bitsSeen = 0; sinceEdge = 0; capt = '0; halfOk = 1'b1; csOk = 1'b1;
        if (!cphaT) sdi = cur.rx[cur.len - 1];
      end else if (inFrame && chipSel !== 4'hF) begin
        sinceEdge++;
        if (chipSel !== cur.cs) csOk = 1'b0;
        if (sclk !== sclkPrev) begin
          bit lead;
          lead = (sclkPrev == cpolT);
          if (sinceEdge != divT + 1) halfOk = 1'b0;
          sinceEdge = 0;
          if (cphaT ? !lead : lead) begin
            capt = {capt[14:0], sdo};
            bitsSeen++;
          end
          if ((cphaT ? lead : !lead) && bitsSeen < cur.len)
            sdi = cur.rx[cur.len - 1 - bitsSeen];
        end
      end else if (inFrame) begin
        inFrame = 1'b0;
        chk(csOk, "R4", "chip select held at entry code", 0, int'(cur.cs));
        chk(bitsSeen == cur.len, "R5", "bit count", bitsSeen, cur.len);
        chk((capt & maskOf(cur.len)) === (cur.tx & maskOf(cur.len)), "R5", "bits sent",
            int'(capt & maskOf(cur.len)), int'(cur.tx & maskOf(cur.len)));
        chk(halfOk, "R8", "half period equals div+1", 0, divT + 1);
        chk(sclk === cpolT, "R7", "clock rest level after entry", int'(sclk), int'(cpolT));
      end
      sclkPrev = sclk;
    end
  end

  initial begin
    #(8 * 190000);
    chk(1'b0, "R9", "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(chipSel === 4'hF, "R1", "chipSel reset", int'(chipSel), 15);
    chk(sclk === 1'b0, "R1", "sclk reset", int'(sclk), 0);
    chk(sdo === 1'b0, "R1", "sdo reset", int'(sdo), 0);
    chk(done === 1'b0, "R1", "done reset", int'(done), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R2 register readback
    hostWrite(6'h07, 16'h00A5);
    hostRead(6'h07, v);  chk(v === 16'h00A5, "R2", "command readback", int'(v), 'hA5);
    hostWrite(6'h17, 16'hBEEF);
    hostRead(6'h17, v);  chk(v === 16'hBEEF, "R2", "transmit readback", int'(v), 'hBEEF);
    hostWrite(6'h30, 16'h0321);
    hostRead(6'h30, v);  chk(v === 16'h0021, "R2", "pointer readback", int'(v), 'h21);
    hostWrite(6'h31, 16'h0003);
    hostRead(6'h31, v);  chk(v === 16'h0003, "R2", "mode readback", int'(v), 3);
    hostWrite(6'h32, 16'h01C7);
    hostRead(6'h32, v);  chk(v === 16'h00C7, "R2", "divider readback", int'(v), 'hC7);

    // Run A: polarity 0 phase 0, three byte entries 0..2
    setMode(1'b0, 1'b0, 0, 0, 2);
    addEntry(0, 4'h1, 8, 16'h0090, 16'h0000);
    addEntry(1, 4'h1, 8, 16'h0000, 16'h005A);
    addEntry(2, 4'h2, 8, 16'h0000, 16'h00C3);
    hostWrite(6'h33, 16'h0000);
    waitDone("A");
    for (int i = 0; i < 3; i++) checkRx(i);

    // Run B: polarity 1 phase 1, wrap 14 -> 1, writes during the run
    setMode(1'b1, 1'b1, 3, 14, 1);
    addEntry(14, 4'h3, 1, 16'h0001, 16'h0001);
    addEntry(15, 4'h4, 16, 16'hA5C3, 16'h3CF0);
    addEntry(0, 4'h5, 5, 16'h0015, 16'h000A);
    addEntry(1, 4'h6, 16, 16'h8001, 16'hFFFF);
    hostWrite(6'h33, 16'h0000);
    chk(done === 1'b0, "R9", "done cleared by start", int'(done), 0);
    repeat (10) @(negedge clk);
    hostWrite(6'h30, 16'h0077);   // R10 ignored while busy
    hostWrite(6'h33, 16'h0000);   // R10 restart ignored
    hostWrite(6'h11, 16'h1234);   // R10 entry 1 still sends 0x8001
    waitDone("B");
    hostRead(6'h30, v);  chk(v === 16'h001E, "R10", "pointers unchanged by busy write", int'(v), 'h1E);
    hostRead(6'h11, v);  chk(v === 16'h8001, "R10", "transmit unchanged by busy write", int'(v), 'h8001);
    checkRx(14); checkRx(15); checkRx(0); checkRx(1);

    // Run C: polarity 0 phase 1, single entry (start equals end), upper rx bits zeroed
    setMode(1'b0, 1'b1, 1, 5, 5);
    addEntry(5, 4'h7, 12, 16'h0ABC, 16'hFF0F);
    hostWrite(6'h33, 16'h0000);
    waitDone("C");
    checkRx(5);

    // Run D: polarity 1 phase 0
    setMode(1'b1, 1'b0, 2, 8, 9);
    addEntry(8, 4'h0, 16, 16'hFFFF, 16'h0000);
    addEntry(9, 4'hE, 3, 16'h0006, 16'h0005);
    hostWrite(6'h33, 16'h0000);
    waitDone("D");
    checkRx(8); checkRx(9);
    repeat (30) @(negedge clk);
    chk(done === 1'b1, "R9", "done holds until next start", int'(done), 1);
    chk(sclk === 1'b1, "R7", "clock rests high with polarity 1", int'(sclk), 1);
    chk(chipSel === 4'hF, "R4", "chip select inactive after run", int'(chipSel), 15);

    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule